// File: doc/BRIEF.md
# Burst-limited FIFO transfer splitter

This block moves a buffer of N bytes between a local byte buffer and the data FIFO register of a security device that sits behind a register-access transport. The device caps how many bytes it accepts or delivers per register access. It advertises that limit, the burst count, in a 16-bit field of its 32-bit status register. The splitter cuts the buffer into a series of FIFO register transactions. Before each one it reads the status register again and sizes the next piece from the fresh burst count.

A caller pulses `start_i` with a direction and a length. The block then works through four states. `ST_IDLE` waits for a start. `ST_STATUS` issues a 4-byte status read at offset 0x18 and collects the status bytes. `ST_CHUNK` issues one FIFO access at offset 0x24 and moves payload bytes. `ST_FINISH` raises `done_o` for one cycle, with `err_o` when the transfer was aborted.

The transitions are as follows. `ST_IDLE` to `ST_STATUS` on a start with nonzero length. `ST_IDLE` to `ST_FINISH` on a zero-length start. `ST_STATUS` to `ST_STATUS` when the burst count is zero. `ST_STATUS` to `ST_CHUNK` when the count is nonzero. `ST_STATUS` or `ST_CHUNK` to `ST_FINISH` on a transaction error. `ST_CHUNK` to `ST_STATUS` while bytes remain. `ST_CHUNK` to `ST_FINISH` when the last byte has moved. `ST_FINISH` to `ST_IDLE` always.

The transaction port is level-based. A request is held until the transport pulses `req_done_i`. Each byte moved inside a transaction is marked by `xfer_strobe_i`.

Top module: `fifo_burst_splitter`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `err_o` and `req_valid_o` are all low.
- R2: A start with length zero raises `done_o` (with `err_o` low) on the cycle after the start, and issues no request.
- R3: Every FIFO transaction is preceded by a status read: a read request (`req_write_o`=0) at address 0x18 with `req_len_o`=4. The four bytes received are assembled little-endian (first byte into bits 7:0), and the burst count is bits 23:8.
- R4: When the burst count read is zero, the block issues another status read and no FIFO transaction.
- R5: Each FIFO transaction length is min(bytes remaining, burst count, MAX_CHUNK), where MAX_CHUNK defaults to 64.
- R6: Each piece is one request at address 0x24. `req_write_o` is 1 when `dir_rd_i` was 0 (buffer to device) and 0 when `dir_rd_i` was 1 (device to buffer).
- R7: When the bytes moved equal the requested length, `done_o` pulses for one cycle with `err_o` low, and no further request is issued.
- R8: A `req_err_i` on any transaction ends the transfer: `done_o` pulses with `err_o` high and no further request follows.
- R9: `buf_addr_o` equals the number of payload bytes already moved. Read data is written to consecutive buffer addresses, and write data is fetched from consecutive addresses, in order across pieces.
- R10: While a request waits for `req_done_i`, its address, length and direction stay unchanged.
- R11: A start pulse while the block is busy is ignored; the running transfer continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a transfer (accepted only when idle) |
| dir_rd_i | input | 1 | 1: device to buffer, 0: buffer to device |
| len_i | input | LEN_W | Total number of bytes |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Aborted, valid with `done_o` |
| req_valid_o | output | 1 | Register transaction requested |
| req_write_o | output | 1 | Transaction is a write |
| req_addr_o | output | ADDR_W | Register offset |
| req_len_o | output | CHUNK_W | Transaction byte count |
| req_done_i | input | 1 | Transaction finished |
| req_err_i | input | 1 | Transaction failed, valid with `req_done_i` |
| xfer_strobe_i | input | 1 | One byte moved in the current transaction |
| xfer_rdata_i | input | 8 | Byte received from the device |
| xfer_wdata_o | output | 8 | Byte sent to the device |
| buf_addr_o | output | LEN_W | Local buffer address |
| buf_rdata_i | input | 8 | Local buffer read data (combinational on address) |
| buf_we_o | output | 1 | Local buffer write enable |
| buf_wdata_o | output | 8 | Local buffer write data |

## Verification
The hardest case to reach is the interleaving of zero burst counts, counts above the piece cap, and remaining-byte limits inside one transfer. Only that mix exercises every status-loop transition together with the three-way minimum. The bench's device model returns a burst count computed from the transfer length and the status-read index. This yields zeros, small counts, counts above the cap and a count with a nonzero upper byte. The bench sweeps every length from 0 to 40 in both directions, and for each transfer it recomputes the expected piece list arithmetically. Errors are injected on a status read, on a first piece and on a later request to reach the abort paths.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STATUS,
        ST_CHUNK,
        ST_FINISH
    } fbs_state_e;
endpackage

// File: rtl/fbs_status_capture.sv
module fbs_status_capture #(
    parameter int BURST_LSB = 8,
    parameter int BURST_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               byte_valid_i,
    input  logic [7:0]         byte_i,
    output logic [BURST_W-1:0] burst_o
);
    logic [1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) idx_q <= '0;
        else if (byte_valid_i) idx_q <= idx_q + 2'd1;
    end

    // Little-endian assembly: byte k of the stream carries status bits 8k+7..8k.
    for (genvar j = 0; j < BURST_W; j++) begin : g_bit
        localparam int SRC = BURST_LSB + j;
        always_ff @(posedge clk) begin
            if (!rst_n) burst_o[j] <= 1'b0;
            else if (byte_valid_i && idx_q == 2'(SRC / 8)) burst_o[j] <= byte_i[SRC % 8];
        end
    end
endmodule

// File: rtl/fbs_chunk_sizer.sv
module fbs_chunk_sizer #(
    parameter int LEN_W     = 16,
    parameter int BURST_W   = 16,
    parameter int MAX_CHUNK = 64,
    parameter int CHUNK_W   = 7
) (
    input  logic [LEN_W-1:0]   remain_i,
    input  logic [BURST_W-1:0] burst_i,
    output logic [CHUNK_W-1:0] chunk_o
);
    logic [CHUNK_W-1:0] rem_c, bur_c;

    always_comb begin
        rem_c = (remain_i > LEN_W'(MAX_CHUNK)) ? CHUNK_W'(MAX_CHUNK) : remain_i[CHUNK_W-1:0];
        bur_c = (burst_i > BURST_W'(MAX_CHUNK)) ? CHUNK_W'(MAX_CHUNK) : burst_i[CHUNK_W-1:0];
        chunk_o = (rem_c < bur_c) ? rem_c : bur_c;
    end
endmodule

// File: rtl/fifo_burst_splitter.sv
module fifo_burst_splitter
    import fbs_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int ADDR_W    = 16,
    parameter int MAX_CHUNK = 64,
    parameter int BURST_LSB = 8,
    parameter int BURST_W   = 16,
    parameter logic [ADDR_W-1:0] STS_ADDR  = 'h18,
    parameter logic [ADDR_W-1:0] FIFO_ADDR = 'h24,
    localparam int CHUNK_W = $clog2(MAX_CHUNK + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               dir_rd_i,
    input  logic [LEN_W-1:0]   len_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               err_o,
    output logic               req_valid_o,
    output logic               req_write_o,
    output logic [ADDR_W-1:0]  req_addr_o,
    output logic [CHUNK_W-1:0] req_len_o,
    input  logic               req_done_i,
    input  logic               req_err_i,
    input  logic               xfer_strobe_i,
    input  logic [7:0]         xfer_rdata_i,
    output logic [7:0]         xfer_wdata_o,
    output logic [LEN_W-1:0]   buf_addr_o,
    input  logic [7:0]         buf_rdata_i,
    output logic               buf_we_o,
    output logic [7:0]         buf_wdata_o
);
    localparam logic [CHUNK_W-1:0] STS_LEN = CHUNK_W'(4);

    fbs_state_e         state_q, state_d;
    logic               dir_q, err_q;
    logic [LEN_W-1:0]   len_q, pos_q, off_q, remain;
    logic [CHUNK_W-1:0] chunk_q, chunk_next;
    logic [BURST_W-1:0] burst;

    assign remain = len_q - pos_q;

    fbs_status_capture #(.BURST_LSB(BURST_LSB), .BURST_W(BURST_W)) u_sts (
        .clk(clk), .rst_n(rst_n),
        .clear_i(state_q != ST_STATUS || req_done_i),
        .byte_valid_i(state_q == ST_STATUS && xfer_strobe_i),
        .byte_i(xfer_rdata_i),
        .burst_o(burst)
    );

    fbs_chunk_sizer #(.LEN_W(LEN_W), .BURST_W(BURST_W), .MAX_CHUNK(MAX_CHUNK),
                      .CHUNK_W(CHUNK_W)) u_size (
        .remain_i(remain), .burst_i(burst), .chunk_o(chunk_next)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = (len_i == '0) ? ST_FINISH : ST_STATUS;
            ST_STATUS: if (req_done_i) begin
                           if (req_err_i)          state_d = ST_FINISH;
                           else if (burst == '0)   state_d = ST_STATUS;
                           else                    state_d = ST_CHUNK;
                       end
            ST_CHUNK:  if (req_done_i) begin
                           if (req_err_i || remain == LEN_W'(chunk_q)) state_d = ST_FINISH;
                           else                                        state_d = ST_STATUS;
                       end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= 1'b0;
            err_q   <= 1'b0;
            len_q   <= '0;
            pos_q   <= '0;
            off_q   <= '0;
            chunk_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    dir_q <= dir_rd_i;
                    len_q <= len_i;
                    pos_q <= '0;
                    off_q <= '0;
                    err_q <= 1'b0;
                end
                ST_STATUS: if (req_done_i) begin
                    err_q   <= req_err_i;
                    chunk_q <= chunk_next;
                end
                ST_CHUNK: begin
                    if (req_done_i) begin
                        pos_q <= pos_q + LEN_W'(chunk_q);
                        off_q <= '0;
                        err_q <= req_err_i;
                    end else if (xfer_strobe_i) begin
                        off_q <= off_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy_o       = (state_q != ST_IDLE);
        done_o       = (state_q == ST_FINISH);
        err_o        = (state_q == ST_FINISH) && err_q;
        req_valid_o  = (state_q == ST_STATUS) || (state_q == ST_CHUNK);
        req_write_o  = (state_q == ST_CHUNK) && !dir_q;
        req_addr_o   = (state_q == ST_CHUNK) ? FIFO_ADDR : STS_ADDR;
        req_len_o    = (state_q == ST_CHUNK) ? chunk_q : STS_LEN;
        buf_addr_o   = pos_q + off_q;
        buf_we_o     = (state_q == ST_CHUNK) && dir_q && xfer_strobe_i;
        buf_wdata_o  = xfer_rdata_i;
        xfer_wdata_o = buf_rdata_i;
    end

    // R5
    chunk_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_addr_o == FIFO_ADDR) |->
            (req_len_o != '0 && req_len_o <= CHUNK_W'(MAX_CHUNK) && LEN_W'(req_len_o) <= remain));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_done_i) |=>
            (req_valid_o && $stable(req_addr_o) && $stable(req_len_o) && $stable(req_write_o)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !req_valid_o));

    // R8
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    // R9
    pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (pos_q <= len_q));

    // R2
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && len_i == '0) |=> (done_o && !err_o && !req_valid_o));
endmodule

// File: tb/fifo_burst_splitter_test.sv
module fifo_burst_splitter_test;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 16;
    localparam int ADDR_W = 16;
    localparam int MAXC = 8;
    localparam int CW = $clog2(MAXC + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, dir_rd_i = 1'b0;
    logic [LEN_W-1:0] len_i = '0;
    logic busy_o, done_o, err_o, req_valid_o, req_write_o;
    logic [ADDR_W-1:0] req_addr_o;
    logic [CW-1:0] req_len_o;
    logic req_done_i = 1'b0, req_err_i = 1'b0, xfer_strobe_i = 1'b0;
    logic [7:0] xfer_rdata_i = '0;
    logic [7:0] xfer_wdata_o, buf_rdata_i, buf_wdata_o;
    logic [LEN_W-1:0] buf_addr_o;
    logic buf_we_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fifo_burst_splitter #(.LEN_W(LEN_W), .ADDR_W(ADDR_W), .MAX_CHUNK(MAXC)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_rd_i(dir_rd_i), .len_i(len_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .req_valid_o(req_valid_o), .req_write_o(req_write_o), .req_addr_o(req_addr_o),
        .req_len_o(req_len_o), .req_done_i(req_done_i), .req_err_i(req_err_i),
        .xfer_strobe_i(xfer_strobe_i), .xfer_rdata_i(xfer_rdata_i), .xfer_wdata_o(xfer_wdata_o),
        .buf_addr_o(buf_addr_o), .buf_rdata_i(buf_rdata_i), .buf_we_o(buf_we_o),
        .buf_wdata_o(buf_wdata_o)
    );

    int checks = 0, errors = 0;
    int cur_len = 0, cur_dir = 0, err_req = -1;
    logic [7:0] seed8 = '0;
    int n_sts, n_chunks, n_req, dev_pos, proto_bad;
    int act_size [0:63];
    logic [7:0] dev_rx [0:255];
    logic [7:0] mem [0:255];

    assign buf_rdata_i = (buf_addr_o[7:0] * 8'd29 + seed8) ^ 8'h55;

    always @(posedge clk) if (buf_we_o) mem[buf_addr_o[7:0]] <= buf_wdata_o;

    function automatic int burst_of(input int len, input int k);
        int v;
        v = (k * 5 + len * 3) % 11;
        return (v == 10) ? 32'h0200 : v;
    endfunction

    function automatic logic [7:0] rd_pat(input int p, input logic [7:0] s);
        return 8'(p * 13) + s * 8'd7 + 8'd1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Device model on the register-transaction port
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && req_valid_o) begin
                automatic int ln = int'(req_len_o);
                automatic bit is_sts = (req_addr_o == 16'h0018);
                automatic logic [31:0] sts = '0;
                if (is_sts) begin
                    sts = {8'h5A, 16'(burst_of(cur_len, n_sts)), 8'hC3};
                    n_sts++;
                    if (ln != 4 || req_write_o) proto_bad++;
                end else begin
                    if (req_addr_o != 16'h0024 || req_write_o != (cur_dir == 0)) proto_bad++;
                    if (n_chunks < 64) act_size[n_chunks] = ln;
                    n_chunks++;
                end
                repeat (n_req % 2) @(negedge clk);
                for (int i = 0; i < ln; i++) begin
                    xfer_strobe_i = 1'b1;
                    xfer_rdata_i = is_sts ? sts[8*i +: 8] : rd_pat(dev_pos, seed8);
                    #1;
                    if (!is_sts) begin
                        if (cur_dir == 0) dev_rx[dev_pos[7:0]] = xfer_wdata_o;
                        dev_pos++;
                    end
                    @(negedge clk);
                end
                xfer_strobe_i = 1'b0;
                req_done_i = 1'b1;
                req_err_i = (n_req == err_req);
                n_req++;
                @(negedge clk);
                req_done_i = 1'b0;
                req_err_i = 1'b0;
            end
        end
    end

    task automatic run_transfer(input int dir, input int len, input int ereq, input bit restart_busy);
        int waits, rem, k, b, c, exp_n;
        int exp_size [0:63];
        bit exp_err;
        cur_len = len; cur_dir = dir; err_req = ereq;
        seed8 = seed8 + 8'd1;
        n_sts = 0; n_chunks = 0; n_req = 0; dev_pos = 0; proto_bad = 0;
        @(negedge clk);
        start_i = 1'b1; dir_rd_i = dir[0]; len_i = LEN_W'(len);
        @(negedge clk);
        start_i = 1'b0;
        waits = 0;
        while (!done_o && waits < 5000) begin
            if (restart_busy && waits == 3) begin
                start_i = 1'b1; dir_rd_i = ~dir[0]; len_i = LEN_W'(len + 20);
            end else start_i = 1'b0;
            @(negedge clk);
            waits++;
        end
        start_i = 1'b0;
        check(done_o, "R7 done seen", int'(done_o), 1);
        if (len == 0) begin
            check(waits == 0 && !err_o, "R2 zero length done next cycle", waits, 0);
            check(n_sts == 0 && n_chunks == 0, "R2 zero length no traffic", n_sts + n_chunks, 0);
        end
        exp_err = (ereq >= 0);
        check(err_o == exp_err, exp_err ? "R8 err flag" : "R7 err flag", int'(err_o), int'(exp_err));
        check(proto_bad == 0, "R3 R6 request fields", proto_bad, 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (req_valid_o) begin
                check(0, exp_err ? "R8 request after abort" : "R7 request after done", 1, 0);
                break;
            end
        end
        if (!exp_err) begin
            rem = len; k = 0; exp_n = 0;
            while (rem > 0 && k < 1000) begin
                b = burst_of(len, k); k++;
                if (b == 0) continue;
                c = rem; if (b < c) c = b; if (MAXC < c) c = MAXC;
                if (exp_n < 64) exp_size[exp_n] = c;
                exp_n++; rem -= c;
            end
            check(n_sts == k, "R3 R4 status read count", n_sts, k);
            check(n_chunks == exp_n, "R5 piece count", n_chunks, exp_n);
            for (int i = 0; i < exp_n && i < 64 && i < n_chunks; i++)
                if (act_size[i] != exp_size[i]) begin
                    check(0, "R5 piece size", act_size[i], exp_size[i]);
                    break;
                end
            for (int p = 0; p < len; p++) begin
                if (dir == 1 && mem[p] != rd_pat(p, seed8)) begin
                    check(0, restart_busy ? "R11 read data" : "R9 read data order", int'(mem[p]), int'(rd_pat(p, seed8)));
                    break;
                end
                if (dir == 0 && dev_rx[p] != ((8'(p) * 8'd29 + seed8) ^ 8'h55)) begin
                    check(0, "R9 write data order", int'(dev_rx[p]), int'((8'(p) * 8'd29 + seed8) ^ 8'h55));
                    break;
                end
            end
            check(dev_pos == len, restart_busy ? "R11 byte total" : "R9 byte total", dev_pos, len);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !err_o && !req_valid_o, "R1 reset state",
              int'({busy_o, done_o, err_o, req_valid_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !req_valid_o, "R1 idle after reset", int'({busy_o, req_valid_o}), 0);
        for (int d = 0; d < 2; d++)
            for (int l = 0; l <= 40; l++)
                run_transfer(d, l, -1, 1'b0);
        run_transfer(1, 10, -1, 1'b1);   // R11
        run_transfer(1, 20, 0, 1'b0);    // R8 status error
        run_transfer(0, 20, 1, 1'b0);    // R8 first piece error
        run_transfer(1, 33, 5, 1'b0);    // R8 later error
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule